// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. A free-running divider makes an oversampling tick. A single state machine finds the start bit, confirms it at mid-bit, shifts in eight data bits least significant bit first, and checks the stop bit. The oversampling density is set per frame: either 16 ticks per bit or 4 ticks per bit. The frame may end in one stop bit or two. When two are selected, only the second stop bit decides the framing result, and the first is passed over.

A two-bit operating-mode input selects infrared operation with the value 2'b11. In that mode, every oversampling tick appears as a one-cycle pulse on a dedicated clock output. This happens without a break, whether the receiver is idle or busy with a frame. With 16x oversampling, this pulse train is the 16x baud clock needed by an external infrared front end.

The states are IDLE, START, DATA, STOP1 and STOP2. The transitions are:
- IDLE to START on a falling edge of the synchronised line.
- START to IDLE (false start) when the mid-bit sample is high.
- START to DATA when the mid-bit sample is low.
- DATA to STOP1 after the eighth bit.
- STOP1 to IDLE when one stop bit is selected, or STOP1 to STOP2 when two are selected.
- STOP2 to IDLE after the second stop bit is sampled.

Top module: `uart_os_rx`

## Requirements
- R1: The oversampling tick repeats every div_i+1 clock cycles. A counter reloads from div_i each time it reaches zero.
- R2: With hs_i=0, a bit lasts 16 ticks, and the start bit is confirmed on the 8th tick after the falling edge. Eight data bits are then sampled one bit apart, least significant bit first. They are presented on data_o with a one-cycle valid_o pulse.
- R3: With hs_i=1, a bit lasts 4 ticks, and the start bit is confirmed on the 2nd tick. Reception is otherwise the same as in R2.
- R4: hs_i and two_stop_i are captured at the start-bit edge. Consecutive frames may use different oversampling settings.
- R5: A low pulse that has ended before the start-bit confirmation sample produces no byte.
- R6: With two_stop_i=0, a low stop bit sets ferr_o=1, and a high stop bit sets ferr_o=0. The byte is delivered with valid_o in both cases.
- R7: With two_stop_i=1, ferr_o follows the second stop bit only, in both oversampling settings. A low first stop bit followed by a high second stop bit gives ferr_o=0, and the reverse gives ferr_o=1.
- R8: data_o and ferr_o change only in the cycle where valid_o is high. They hold their values until the next byte.
- R9: When mode_i==2'b11, bclk_o pulses once per tick, both idle and while receiving. For any other mode_i value, bclk_o stays 0.
- R10: After reset, valid_o, ferr_o, bclk_o and data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Serial line, idles high |
| div_i | input | DIV_W | Tick divisor; tick period is div_i+1 clocks |
| hs_i | input | 1 | 0: 16 ticks per bit, 1: 4 ticks per bit |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| mode_i | input | 2 | 2'b11 selects infrared operation |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a new byte |
| ferr_o | output | 1 | Framing error of the last byte |
| bclk_o | output | 1 | Tick pulses in infrared mode |

## Verification
The assertions watch, on every cycle, the following properties:
- valid_o is only ever a single-cycle strobe.
- data_o and ferr_o move only together with that strobe.
- bclk_o appears only after infrared mode was selected.
- bclk_o never repeats on consecutive cycles while the divisor is non-zero.

The following can only be shown by the bench's scenarios, which drive whole frames:
- the bit order and sampling points in each oversampling setting;
- the rejection of short glitches;
- the change of setting between frames;
- which stop bit decides the framing error;
- the exact tick spacing.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
    localparam int BYTE_W = 8;
    localparam int TCNT_W = 4;
    localparam logic [1:0] IR_MODE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;
endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/uart_os_baud.sv
module uart_os_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == '0)   cnt <= div_i;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick_o = (cnt == '0);
endmodule

// File: rtl/uart_os_fsm.sv
module uart_os_fsm
    import uart_os_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              hs_i,
    input  logic              two_stop_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o
);
    localparam logic [TCNT_W-1:0] LAST16 = TCNT_W'(15);
    localparam logic [TCNT_W-1:0] LAST4  = TCNT_W'(3);
    localparam logic [TCNT_W-1:0] HALF16 = TCNT_W'(7);
    localparam logic [TCNT_W-1:0] HALF4  = TCNT_W'(1);
    localparam int BCNT_W = $clog2(BYTE_W);

    rx_state_t           state, state_nx;
    logic [TCNT_W-1:0]   tcnt;
    logic [BCNT_W-1:0]   bcnt;
    logic [BYTE_W-1:0]   shreg;
    logic                hs_q, two_q, rx_prev;
    logic                fall, bit_end, mid_hit, done;
    logic [TCNT_W-1:0]   last_t, half_t;

    assign last_t  = hs_q ? LAST4 : LAST16;
    assign half_t  = hs_q ? HALF4 : HALF16;
    assign fall    = rx_prev && !rx_i;
    assign bit_end = tick_i && (tcnt == last_t);
    assign mid_hit = tick_i && (tcnt == half_t);
    assign done    = ((state == ST_STOP1) && bit_end && !two_q) ||
                     ((state == ST_STOP2) && bit_end);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fall)    state_nx = ST_START;
            ST_START: if (mid_hit) state_nx = rx_i ? ST_IDLE : ST_DATA;
            ST_DATA:  if (bit_end && bcnt == BCNT_W'(BYTE_W-1)) state_nx = ST_STOP1;
            ST_STOP1: if (bit_end) state_nx = two_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (bit_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register and receive datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            hs_q    <= 1'b0;
            two_q   <= 1'b0;
            rx_prev <= 1'b1;
        end else begin
            state   <= state_nx;
            rx_prev <= rx_i;
            unique case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    bcnt <= '0;
                    if (fall) begin
                        hs_q  <= hs_i;
                        two_q <= two_stop_i;
                    end
                end
                ST_START: begin
                    if (mid_hit)     tcnt <= '0;
                    else if (tick_i) tcnt <= tcnt + 1'b1;
                end
                ST_DATA: begin
                    if (bit_end) begin
                        tcnt  <= '0;
                        bcnt  <= bcnt + 1'b1;
                        shreg <= {rx_i, shreg[BYTE_W-1:1]};
                    end else if (tick_i) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP1, ST_STOP2: begin
                    if (bit_end)     tcnt <= '0;
                    else if (tick_i) tcnt <= tcnt + 1'b1;
                end
                default: tcnt <= '0;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) begin
                data_o <= shreg;
                ferr_o <= !rx_i;
            end
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              hs_i,
    input  logic              two_stop_i,
    input  logic [1:0]        mode_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o,
    output logic              bclk_o
);
    logic rx_s;
    logic tick;

    uart_os_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    uart_os_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (tick)
    );

    uart_os_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .rx_i       (rx_s),
        .hs_i       (hs_i),
        .two_stop_i (two_stop_i),
        .data_o     (data_o),
        .valid_o    (valid_o),
        .ferr_o     (ferr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) bclk_o <= 1'b0;
        else     bclk_o <= tick && (mode_i == IR_MODE);
    end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_i,
    input logic [1:0]       mode_i,
    input logic [7:0]       data_o,
    input logic             valid_o,
    input logic             ferr_o,
    input logic             bclk_o
);
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_ferr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(ferr_o));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(data_o));

    assert_bclk_ir_only_R9: assert property (@(posedge clk) disable iff (rst)
        bclk_o |-> ($past(mode_i) == 2'b11));

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (bclk_o && $past(div_i) != '0) |=> !bclk_o);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .div_i   (div_i),
    .mode_i  (mode_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .ferr_o  (ferr_o),
    .bclk_o  (bclk_o)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_i = 1'b1;
    logic [15:0] div_i = 16'd3;
    logic        hs_i = 1'b0;
    logic        two_stop_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  data_o;
    logic        valid_o, ferr_o, bclk_o;

    int checks = 0, failures = 0;
    int nvalid = 0, nbclk = 0, cyc = 0, last_b = -1, gmin = 1000000, gmax = 0;
    logic [7:0] cap_d;
    logic       cap_f;

    always #4 clk = ~clk;

    uart_os_rx u0 (
        .clk(clk), .rst(rst), .rx_i(rx_i), .div_i(div_i), .hs_i(hs_i),
        .two_stop_i(two_stop_i), .mode_i(mode_i), .data_o(data_o),
        .valid_o(valid_o), .ferr_o(ferr_o), .bclk_o(bclk_o)
    );

    always @(negedge clk) begin
        cyc++;
        if (valid_o) begin
            nvalid++;
            cap_d = data_o;
            cap_f = ferr_o;
        end
        if (bclk_o) begin
            nbclk++;
            if (last_b >= 0) begin
                if (cyc - last_b < gmin) gmin = cyc - last_b;
                if (cyc - last_b > gmax) gmax = cyc - last_b;
            end
            last_b = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_bclk();
        nbclk = 0; last_b = -1; gmin = 1000000; gmax = 0;
    endtask

    task automatic run_frame(input logic [7:0] b, input logic hs, input logic two,
                             input logic s1, input logic s2, input logic exp_f,
                             input string req);
        int p;
        p = (hs ? 4 : 16) * (int'(div_i) + 1);
        @(negedge clk);
        hs_i = hs; two_stop_i = two; nvalid = 0;
        rx_i = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            repeat (p) @(negedge clk);
        end
        rx_i = s1;
        repeat (p) @(negedge clk);
        if (two) begin
            rx_i = s2;
            repeat (p) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (2 * p) @(negedge clk);
        check(nvalid == 1, req, "valid count", nvalid, 1);
        check(cap_d == b, req, "data", cap_d, b);
        check(cap_f == exp_f, req, "ferr", cap_f, exp_f);
    endtask

    task automatic t_reset();
        check(valid_o == 0 && ferr_o == 0 && bclk_o == 0 && data_o == 0, "R10",
              "reset outputs", {valid_o, ferr_o, bclk_o, data_o}, 0);
    endtask

    task automatic t_basic16();
        run_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        run_frame(8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        run_frame(8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_basic4();
        run_frame(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        run_frame(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_switch();
        run_frame(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        run_frame(8'hC3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        run_frame(8'h96, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_glitch();
        @(negedge clk);
        hs_i = 1'b0; nvalid = 0;
        rx_i = 1'b0;
        repeat (2 * (int'(div_i) + 1)) @(negedge clk);
        rx_i = 1'b1;
        repeat (16 * 4 * (int'(div_i) + 1)) @(negedge clk);
        check(nvalid == 0, "R5", "glitch gave byte", nvalid, 0);
        run_frame(8'h42, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_stop_one();
        run_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        // R8: error and byte held while idle
        repeat (50) @(negedge clk);
        check(ferr_o == 1'b1, "R8", "ferr held", ferr_o, 1);
        check(data_o == 8'h00, "R8", "data held", data_o, 0);
        run_frame(8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        run_frame(8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_stop_two();
        run_frame(8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        run_frame(8'h22, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        run_frame(8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        run_frame(8'h44, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_ir();
        mode_i = 2'b01;
        repeat (10) @(negedge clk);
        clr_bclk();
        repeat (40) @(negedge clk);
        check(nbclk == 0, "R9", "bclk outside IR", nbclk, 0);
        mode_i = 2'b11;
        repeat (10) @(negedge clk);
        clr_bclk();
        repeat (40) @(negedge clk);
        check(nbclk == 10, "R9", "idle bclk count", nbclk, 10);
        check(gmin == 4 && gmax == 4, "R1", "tick gap div=3", gmax, 4);
        clr_bclk();
        run_frame(8'hE7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        check(gmin == 4 && gmax == 4, "R9", "gap while receiving", gmin, 4);
        div_i = 16'd6;
        repeat (20) @(negedge clk);
        clr_bclk();
        repeat (70) @(negedge clk);
        check(gmin == 7 && gmax == 7, "R1", "tick gap div=6", gmax, 7);
        check(nbclk == 10, "R1", "bclk count div=6", nbclk, 10);
        mode_i = 2'b00;
        div_i = 16'd3;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_basic16();
        t_basic4();
        t_switch();
        t_glitch();
        t_stop_one();
        t_stop_two();
        t_ir();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule